// File: doc/BRIEF.md
# I2C Master Byte-Transfer Controller

This block is a single-master I2C controller that software drives one byte at a time through four small registers. Software loads a byte into the data register. It then writes the control register with per-byte flags: a START before the byte, a STOP after it, and the acknowledge level to return on a read. In the same write it sets a transfer bit. The controller shifts exactly one byte on the bus and clears the transfer bit when it is finished. It reports the outcome through sticky status flags that software clears by writing ones to them.

A transaction is built from a series of such commands. A byte sent with START is the address byte, and its bit 0 selects the direction of the bytes that follow. The controller holds SCL low between bytes until software issues the next command. It flags a slave that does not acknowledge, and after a lost arbitration it retries the address byte by itself once the bus is free again. Open-drain pins are modelled as pull-low enables paired with the sensed line levels.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) read 0. Both pull-low outputs are inactive. With an idle bus the pin monitor (address 3) reads 3.
- R2: A transfer started with control bit 0 (START) set produces a START condition, meaning SDA falls while SCL is high. The data byte then follows MSB first. Status bit 0 takes bit 0 of that byte, where 1 means read.
- R3: Control bit 3 (transfer) clears itself when the byte is done. A write byte sets status bit 6 (transmit done), and with no STOP requested the controller then holds SCL low.
- R4: Control bit 1 (STOP) appends a STOP condition after the acknowledge clock, meaning SDA rises while SCL is high, and leaves both lines released. Status bit 2 (unit busy) stays 1 from the START byte until that STOP completes. Status bit 3 (bus busy) is 1 between a START and a STOP seen on the lines.
- R5: When status bit 0 is 1 and START is clear, the byte is received: SDA is released for all 8 bits, status bit 7 (receive full) is set, and the data register (address 2) holds the received byte.
- R6: On a received byte, control bit 2 = 0 makes the master pull SDA low on the acknowledge clock, and 1 leaves it high (NAK). Status bit 1 shows the level seen on the acknowledge clock of the last byte.
- R7: A slave that leaves SDA high on the acknowledge clock of a transmitted byte sets status bit 10 (bus error) together with bit 6, and status bit 1 reads 1.
- R8: Writing 1 to status bit 5, 6, 7 or 10 clears that flag. Writing 0 leaves it unchanged.
- R9: While control bit 14 (unit reset) is 1, the status flags, unit busy and the transfer bit read 0, and a transfer bit written in the same word is ignored.
- R10: A transfer bit written while control bit 6 (unit enable) or bit 5 (SCL enable) is 0 is ignored: it reads back 0 and SCL is never pulled.
- R11: If the master releases SDA for a transmitted bit but senses it low while SCL is high, it sets status bit 5 (arbitration lost) and releases both lines. It waits for a STOP on the bus, then repeats the START and the same byte. Output irq is 1 while bit 5 and control bit 12 are both 1.
- R12: Address 3 returns the SCL level in bit 1 and the SDA level in bit 0, each after a two-flop synchronizer.
- R13: A data-bit SCL low phase lasts PHASE_CLKS clocks. The high phase lasts PHASE_CLKS clocks counted once the synchronized SCL is high, which is PHASE_CLKS+2 clocks in total. SDA is held steady during a data-bit high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 pin monitor |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for the selected register |
| irq | output | 1 | Arbitration-loss interrupt |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
Arbitration loss and the retry that follows are the hardest state to reach from the ports. The bench plays a second master. It pulls SDA low during the low phase of the first address bit, which is a 1, and holds it through the high phase so that the controller loses. It then releases SDA while SCL is high, which forms a STOP and frees the bus. A slave model then accepts the repeated START and byte, so the bench can confirm that the full address reached the bus, that the loss flag stayed set, and that the interrupt followed the enable bit.

// File: rtl/i2cm_pkg.sv
// Shared definitions for the I2C byte master: register addresses,
// control and status bit positions, and the bit-engine state type.
package i2cm_pkg;
    localparam int REG_AW = 2;
    localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] A_STAT = 2'd1;
    localparam logic [REG_AW-1:0] A_DATA = 2'd2;
    localparam logic [REG_AW-1:0] A_BMON = 2'd3;

    // control bit positions
    localparam int C_START = 0;
    localparam int C_STOP  = 1;
    localparam int C_NAK   = 2;
    localparam int C_XFER  = 3;
    localparam int C_SCLEN = 5;
    localparam int C_UEN   = 6;
    localparam int C_ALIE  = 12;
    localparam int C_URST  = 14;

    // status bit positions
    localparam int S_RW    = 0;
    localparam int S_ACK   = 1;
    localparam int S_UBSY  = 2;
    localparam int S_BBSY  = 3;
    localparam int S_ALOST = 5;
    localparam int S_TXD   = 6;
    localparam int S_RXF   = 7;
    localparam int S_BERR  = 10;

    typedef enum logic [3:0] {
        E_IDLE, E_RS_LOW, E_ST_HIGH, E_ST_SDA, E_BIT_LOW, E_BIT_HIGH,
        E_SP_LOW, E_SP_HIGH, E_SP_REL, E_WAIT_FREE
    } eng_state_t;
endpackage

// File: rtl/i2cm_sync_mon.sv
// Line monitor: brings the sensed SCL/SDA levels into the clock domain
// with two flops each and tracks bus ownership by watching START and STOP
// conditions. Assumes the lines change slower than two clock periods.
module i2cm_sync_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic bus_busy
);
    logic scl_m, sda_m, sda_prev, scl_prev, busy_q;

    // two-stage synchronizer plus previous-sample registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_m <= 1'b1; sda_m <= 1'b1;
            scl_s <= 1'b1; sda_s <= 1'b1;
            scl_prev <= 1'b1; sda_prev <= 1'b1;
        end else begin
            scl_m <= scl_in; sda_m <= sda_in;
            scl_s <= scl_m;  sda_s <= sda_m;
            scl_prev <= scl_s; sda_prev <= sda_s;
        end
    end

    // bus busy: set on SDA fall with SCL high, cleared on SDA rise with SCL high
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else if (scl_s && scl_prev && sda_prev && !sda_s) busy_q <= 1'b1;
        else if (scl_s && scl_prev && !sda_prev && sda_s) busy_q <= 1'b0;
    end

    assign bus_busy = busy_q;

    // R4
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(scl_s && !sda_s));
endmodule

// File: rtl/i2cm_byte_engine.sv
// Bit engine: on a go pulse it moves one byte on the bus, optionally
// preceded by a (repeated) START and followed by a STOP. SCL phases are
// timed by a counter; the high phase waits for the synchronized SCL to be
// high. On a lost bit it releases the bus, waits for the bus to be free and
// retries the START and byte. Assumes go arrives only while idle.
module i2cm_byte_engine
    import i2cm_pkg::*;
#(
    parameter int PHASE_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       go,
    input  logic       do_start,
    input  logic       do_stop,
    input  logic       do_read,
    input  logic       send_nak,
    input  logic [7:0] tx_byte,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       bus_busy,
    output logic       scl_low,
    output logic       sda_low,
    output logic       done,
    output logic       arb_lost,
    output logic       ack_bit,
    output logic [7:0] rx_byte
);
    localparam int CW = $clog2(PHASE_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

    eng_state_t state_q;
    logic [CW-1:0] cnt_q;
    logic [3:0] bit_q;
    logic [7:0] shift_q, byte_q;
    logic hold_q, stop_q, rd_q, nak_q, done_q, arb_q, ack_q;
    logic cnt_run, adv, bit_val;

    // counter pauses in high phases until SCL is really high (stretching)
    assign cnt_run = !((state_q == E_BIT_HIGH || state_q == E_ST_HIGH) && !scl_s);
    assign adv = cnt_run && (cnt_q == LAST);

    // value this master wants on SDA for the current bit (1 = released)
    always_comb begin
        if (bit_q < 4'd8) bit_val = rd_q ? 1'b1 : shift_q[7];
        else              bit_val = rd_q ? nak_q : 1'b1;
    end

    // pin drive per state
    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        case (state_q)
            E_IDLE:     scl_low = hold_q;
            E_RS_LOW:   scl_low = 1'b1;
            E_ST_SDA:   sda_low = 1'b1;
            E_BIT_LOW:  begin scl_low = 1'b1; sda_low = !bit_val; end
            E_BIT_HIGH: sda_low = !bit_val;
            E_SP_LOW:   begin scl_low = 1'b1; sda_low = 1'b1; end
            E_SP_HIGH:  sda_low = 1'b1;
            default:    ;
        endcase
    end

    // sequencer: phase counting, bit shifting, arbitration and retry
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state_q <= E_IDLE; cnt_q <= '0; bit_q <= '0;
            shift_q <= '0; byte_q <= '0; hold_q <= 1'b0;
            stop_q <= 1'b0; rd_q <= 1'b0; nak_q <= 1'b0;
            done_q <= 1'b0; arb_q <= 1'b0; ack_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            arb_q  <= 1'b0;
            if (state_q != E_IDLE && state_q != E_WAIT_FREE && cnt_run)
                cnt_q <= adv ? '0 : cnt_q + 1'b1;
            case (state_q)
                E_IDLE: if (go) begin
                    cnt_q <= '0; bit_q <= '0;
                    shift_q <= tx_byte; byte_q <= tx_byte;
                    stop_q <= do_stop; rd_q <= do_read; nak_q <= send_nak;
                    if (!do_start)    state_q <= E_BIT_LOW;
                    else if (hold_q)  state_q <= E_RS_LOW;
                    else if (bus_busy) state_q <= E_WAIT_FREE;
                    else              state_q <= E_ST_HIGH;
                end
                E_RS_LOW:  if (adv) state_q <= E_ST_HIGH;
                E_ST_HIGH: if (adv) state_q <= E_ST_SDA;
                E_ST_SDA:  if (adv) state_q <= E_BIT_LOW;
                E_BIT_LOW: if (adv) state_q <= E_BIT_HIGH;
                E_BIT_HIGH: if (adv) begin
                    if (bit_q < 4'd8) begin
                        shift_q <= {shift_q[6:0], sda_s};
                        if (!rd_q && shift_q[7] && !sda_s) begin
                            arb_q <= 1'b1; hold_q <= 1'b0;
                            state_q <= E_WAIT_FREE;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                            state_q <= E_BIT_LOW;
                        end
                    end else begin
                        ack_q <= sda_s;
                        if (stop_q) state_q <= E_SP_LOW;
                        else begin
                            hold_q <= 1'b1; done_q <= 1'b1;
                            state_q <= E_IDLE;
                        end
                    end
                end
                E_SP_LOW:  if (adv) state_q <= E_SP_HIGH;
                E_SP_HIGH: if (adv) state_q <= E_SP_REL;
                E_SP_REL:  if (adv) begin
                    hold_q <= 1'b0; done_q <= 1'b1; state_q <= E_IDLE;
                end
                E_WAIT_FREE: if (!bus_busy) begin
                    shift_q <= byte_q; bit_q <= '0; cnt_q <= '0;
                    state_q <= E_ST_HIGH;
                end
                default: state_q <= E_IDLE;
            endcase
        end
    end

    assign done     = done_q;
    assign arb_lost = arb_q;
    assign ack_bit  = ack_q;
    assign rx_byte  = shift_q;

    // R13
    sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == E_BIT_HIGH && $past(state_q) == E_BIT_HIGH) |-> $stable(sda_low));
    // R11
    arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_q |-> (!scl_low && !sda_low));
endmodule

// File: rtl/i2c_byte_master.sv
// Register front end of the I2C byte master: control, status (write-one-
// to-clear flags), data buffer and pin monitor. A write of the transfer
// bit with the unit enabled launches one byte in the engine; its done
// pulse updates the flags and clears the transfer bit. Assumes a single
// register master issuing one write per strobe.
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int PHASE_CLKS = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_pull,
    output logic          sda_pull
);
    logic start_q, stop_q, nak_q, xfer_q, sclen_q, uen_q, alie_q, urst_q;
    logic rw_q, ack_q, ubsy_q, alost_q, txd_q, rxf_q, berr_q;
    logic cur_rd_q, cur_stop_q;
    logic [7:0] data_q;
    logic scl_s, sda_s, bus_busy;
    logic e_done, e_arb, e_ack;
    logic [7:0] e_rx;
    logic ctrl_wr, stat_wr, go, go_rd;

    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
    assign stat_wr = reg_wr && (reg_addr == A_STAT);
    assign go = ctrl_wr && reg_wdata[C_XFER] && reg_wdata[C_UEN] &&
                reg_wdata[C_SCLEN] && !reg_wdata[C_URST] && !xfer_q && !urst_q;
    assign go_rd = !reg_wdata[C_START] && rw_q;

    i2cm_sync_mon u_mon (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .bus_busy(bus_busy)
    );

    i2cm_byte_engine #(.PHASE_CLKS(PHASE_CLKS)) u_eng (
        .clk(clk), .rst_n(rst_n), .soft_rst(urst_q), .go(go),
        .do_start(reg_wdata[C_START]), .do_stop(reg_wdata[C_STOP]),
        .do_read(go_rd), .send_nak(reg_wdata[C_NAK]), .tx_byte(data_q),
        .scl_s(scl_s), .sda_s(sda_s), .bus_busy(bus_busy),
        .scl_low(scl_pull), .sda_low(sda_pull), .done(e_done),
        .arb_lost(e_arb), .ack_bit(e_ack), .rx_byte(e_rx)
    );

    // control register and self-clearing transfer bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {start_q, stop_q, nak_q, sclen_q, uen_q, alie_q, urst_q} <= '0;
            xfer_q <= 1'b0; cur_rd_q <= 1'b0; cur_stop_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                start_q <= reg_wdata[C_START]; stop_q <= reg_wdata[C_STOP];
                nak_q   <= reg_wdata[C_NAK];   sclen_q <= reg_wdata[C_SCLEN];
                uen_q   <= reg_wdata[C_UEN];   alie_q <= reg_wdata[C_ALIE];
                urst_q  <= reg_wdata[C_URST];
            end
            if (go) begin
                cur_rd_q <= go_rd; cur_stop_q <= reg_wdata[C_STOP];
            end
            if (urst_q)      xfer_q <= 1'b0;
            else if (go)     xfer_q <= 1'b1;
            else if (e_done) xfer_q <= 1'b0;
        end
    end

    // status flags: engine events set, write-one clears, unit reset wipes
    always_ff @(posedge clk) begin
        if (!rst_n || urst_q) begin
            {rw_q, ack_q, ubsy_q, alost_q, txd_q, rxf_q, berr_q} <= '0;
        end else begin
            if (go && reg_wdata[C_START]) begin
                rw_q <= data_q[0]; ubsy_q <= 1'b1;
            end else if (e_done && cur_stop_q) ubsy_q <= 1'b0;
            if (e_done) ack_q <= e_ack;
            if (e_arb) alost_q <= 1'b1;
            else if (stat_wr && reg_wdata[S_ALOST]) alost_q <= 1'b0;
            if (e_done && !cur_rd_q) txd_q <= 1'b1;
            else if (stat_wr && reg_wdata[S_TXD]) txd_q <= 1'b0;
            if (e_done && cur_rd_q) rxf_q <= 1'b1;
            else if (stat_wr && reg_wdata[S_RXF]) rxf_q <= 1'b0;
            if (e_done && !cur_rd_q && e_ack) berr_q <= 1'b1;
            else if (stat_wr && reg_wdata[S_BERR]) berr_q <= 1'b0;
        end
    end

    // data buffer: software load, or received byte on completion
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else if (e_done && cur_rd_q) data_q <= e_rx;
        else if (reg_wr && reg_addr == A_DATA) data_q <= reg_wdata[7:0];
    end

    // read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[C_START] = start_q; reg_rdata[C_STOP] = stop_q;
                reg_rdata[C_NAK] = nak_q;     reg_rdata[C_XFER] = xfer_q;
                reg_rdata[C_SCLEN] = sclen_q; reg_rdata[C_UEN] = uen_q;
                reg_rdata[C_ALIE] = alie_q;   reg_rdata[C_URST] = urst_q;
            end
            A_STAT: begin
                reg_rdata[S_RW] = rw_q;       reg_rdata[S_ACK] = ack_q;
                reg_rdata[S_UBSY] = ubsy_q;   reg_rdata[S_BBSY] = bus_busy;
                reg_rdata[S_ALOST] = alost_q; reg_rdata[S_TXD] = txd_q;
                reg_rdata[S_RXF] = rxf_q;     reg_rdata[S_BERR] = berr_q;
            end
            A_DATA:  reg_rdata[7:0] = data_q;
            default: reg_rdata[1:0] = {scl_s, sda_s};
        endcase
    end

    assign irq = alie_q && alost_q;

    // R3
    xfer_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_q) |-> $past(e_done || urst_q));
    // R4
    ubsy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ubsy_q && !e_done && !urst_q) |=> ubsy_q);
    // R9
    urst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        urst_q |=> (!txd_q && !rxf_q && !alost_q && !berr_q && !xfer_q));
    // R10
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!uen_q && !xfer_q) |-> !scl_pull);
endmodule

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
    localparam int PH = 8;
    localparam int TCK = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic irq, scl_pull, sda_pull;
    logic tb_sda = 1'b0;
    logic scl_line, sda_line;
    int checks = 0, fails = 0;
    bit finished = 0;

    assign scl_line = !scl_pull;
    assign sda_line = !(sda_pull || tb_sda);

    always #(TCK/2) clk = !clk;

    i2c_byte_master #(.PHASE_CLKS(PH)) i_i2c_byte_master (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_in(scl_line), .sda_in(sda_line),
        .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_xfer();
        logic [15:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(2'd0, v);
            if (!v[3]) return;
        end
    endtask

    // slave receiving one byte; optional START wait, acknowledges if asked
    task automatic serve_write(input bit wait_start, input bit do_ack, output logic [7:0] got);
        got = '0;
        if (wait_start) begin
            do @(negedge sda_line); while (!scl_line);
        end
        for (int i = 0; i < 8; i++) begin
            @(posedge scl_line); got = {got[6:0], sda_line};
        end
        @(negedge scl_line); tb_sda = do_ack;
        @(posedge scl_line);
        @(negedge scl_line); tb_sda = 1'b0;
    endtask

    // slave sending one byte; returns the level seen on the ack clock
    task automatic serve_read(input logic [7:0] b, output logic mack);
        tb_sda = !b[7];
        for (int i = 0; i < 8; i++) begin
            @(posedge scl_line);
            @(negedge scl_line);
            tb_sda = (i < 7) ? !b[6-i] : 1'b0;
        end
        @(posedge scl_line); mack = sda_line;
        @(negedge scl_line);
    endtask

    task automatic test_reset_state();
        logic [15:0] v;
        rd(2'd0, v); check("R1 ctrl", v, 16'h0);
        rd(2'd1, v); check("R1 stat", v, 16'h0);
        rd(2'd3, v); check("R1 bmon", v, 16'h3);
        check("R1 pins", {14'd0, scl_pull, sda_pull}, 16'h0);
    endtask

    task automatic test_disabled();
        logic [15:0] v;
        bit pulled = 0;
        wr(2'd2, 16'h00A4);
        wr(2'd0, 16'h0028);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); if (!scl_line) pulled = 1;
        end
        rd(2'd0, v); check("R10 xfer ignored", {15'd0, v[3]}, 16'h0);
        check("R10 scl untouched", {15'd0, pulled}, 16'h0);
        wr(2'd0, 16'h0060);
    endtask

    task automatic test_write_seq();
        logic [15:0] v;
        logic [7:0] got;
        time t0, t1, t2;
        wr(2'd2, 16'h00A4);
        fork
            serve_write(1, 1, got);
            begin wr(2'd0, 16'h0069); wait_xfer(); end
        join
        check("R2 address byte", {8'd0, got}, 16'h00A4);
        rd(2'd1, v);
        check("R2 rw bit write", {15'd0, v[0]}, 16'h0);
        check("R4 unit busy after start", {15'd0, v[2]}, 16'h1);
        check("R4 bus busy after start", {15'd0, v[3]}, 16'h1);
        check("R3 transmit done", {15'd0, v[6]}, 16'h1);
        rd(2'd0, v); check("R3 xfer self-clear", {15'd0, v[3]}, 16'h0);
        wr(2'd1, 16'h0000);
        rd(2'd1, v); check("R8 zero write keeps", {15'd0, v[6]}, 16'h1);
        wr(2'd1, 16'h0040);
        rd(2'd1, v); check("R8 one write clears", {15'd0, v[6]}, 16'h0);
        wr(2'd2, 16'h003C);
        fork
            serve_write(0, 1, got);
            begin wr(2'd0, 16'h0068); wait_xfer(); end
            begin
                @(posedge scl_line); @(negedge scl_line); t0 = $time;
                @(posedge scl_line); t1 = $time;
                @(negedge scl_line); t2 = $time;
            end
        join
        check("R3 data byte", {8'd0, got}, 16'h003C);
        check("R3 scl held low", {15'd0, scl_line}, 16'h0);
        check("R13 low phase", 16'((t1 - t0) / TCK), 16'(PH));
        check("R13 high phase", 16'((t2 - t1) / TCK), 16'(PH + 2));
        wr(2'd2, 16'h005A);
        fork
            serve_write(0, 1, got);
            begin wr(2'd0, 16'h006A); wait_xfer(); end
        join
        check("R4 byte before stop", {8'd0, got}, 16'h005A);
        rd(2'd1, v);
        check("R4 unit busy cleared", {15'd0, v[2]}, 16'h0);
        check("R4 bus busy cleared", {15'd0, v[3]}, 16'h0);
        check("R4 lines released", {14'd0, scl_line, sda_line}, 16'h3);
        wr(2'd1, 16'h04E0);
    endtask

    task automatic test_nak();
        logic [15:0] v;
        logic [7:0] got;
        wr(2'd2, 16'h00A4);
        fork
            serve_write(1, 0, got);
            begin wr(2'd0, 16'h006B); wait_xfer(); end
        join
        rd(2'd1, v); check("R7 bus error on nak", v, 16'h0442);
        wr(2'd1, 16'h0440);
        rd(2'd1, v); check("R8 clear bus error", v, 16'h0002);
    endtask

    task automatic test_read();
        logic [15:0] v;
        logic [7:0] got;
        logic mack;
        wr(2'd2, 16'h00A5);
        fork
            serve_write(1, 1, got);
            begin wr(2'd0, 16'h0069); wait_xfer(); end
        join
        rd(2'd1, v); check("R2 rw bit read", {15'd0, v[0]}, 16'h1);
        wr(2'd1, 16'h0040);
        fork
            serve_read(8'h96, mack);
            begin wr(2'd0, 16'h0068); wait_xfer(); end
        join
        check("R6 master ack low", {15'd0, mack}, 16'h0);
        rd(2'd2, v); check("R5 received byte", v, 16'h0096);
        rd(2'd1, v); check("R5 receive full", v & 16'h04C2, 16'h0080);
        wr(2'd1, 16'h0080);
        fork
            serve_read(8'h3B, mack);
            begin wr(2'd0, 16'h006E); wait_xfer(); end
        join
        check("R6 master nak high", {15'd0, mack}, 16'h1);
        rd(2'd2, v); check("R5 second byte", v, 16'h003B);
        rd(2'd1, v); check("R6 ack status nak", v & 16'h00C6, 16'h0082);
        wr(2'd1, 16'h04E0);
    endtask

    task automatic test_arbitration();
        logic [15:0] v;
        logic [7:0] got;
        wr(2'd2, 16'h00A4);
        fork
            begin
                do @(negedge sda_line); while (!scl_line);
                @(negedge scl_line); tb_sda = 1'b1;
                @(posedge scl_line);
                repeat (PH + 6) @(posedge clk);
                tb_sda = 1'b0;
                serve_write(1, 1, got);
            end
            begin wr(2'd0, 16'h106B); wait_xfer(); end
        join
        check("R11 retried byte", {8'd0, got}, 16'h00A4);
        rd(2'd1, v); check("R11 arbitration flag", v & 16'h0464, 16'h0060);
        check("R11 irq set", {15'd0, irq}, 16'h1);
        wr(2'd1, 16'h0020);
        rd(2'd1, v); check("R8 clear arbitration", {15'd0, v[5]}, 16'h0);
        check("R11 irq cleared", {15'd0, irq}, 16'h0);
    endtask

    task automatic test_unit_reset();
        logic [15:0] v;
        bit pulled = 0;
        rd(2'd1, v); check("R9 flag before reset", {15'd0, v[6]}, 16'h1);
        wr(2'd0, 16'h4060);
        rd(2'd1, v); check("R9 status wiped", v, 16'h0);
        wr(2'd0, 16'h4068);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); if (!scl_line) pulled = 1;
        end
        rd(2'd0, v); check("R9 xfer ignored", v, 16'h4060);
        check("R9 scl untouched", {15'd0, pulled}, 16'h0);
        wr(2'd0, 16'h0060);
    endtask

    task automatic test_monitor();
        logic [15:0] v;
        tb_sda = 1'b1;
        repeat (4) @(posedge clk);
        rd(2'd3, v); check("R12 sda low", v, 16'h0002);
        tb_sda = 1'b0;
        repeat (4) @(posedge clk);
        rd(2'd3, v); check("R12 sda high", v, 16'h0003);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        test_reset_state();
        test_disabled();
        test_write_seq();
        test_nak();
        test_read();
        test_arbitration();
        test_unit_reset();
        test_monitor();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule